// File: doc/BRIEF.md
# Chainable Presettable Binary Up Counter

This block is a 4-bit synchronous binary up counter slice and a wrapper that chains a parameterised number of slices into one wider counter. Each slice can be preset from a parallel data word, cleared to zero, counted up by one, or held. The choice depends on an active-low clear, an active-low load and two count-enable inputs.

The two enables do different jobs. The first one is shared by every slice and acts as a global run or pause control. The second one belongs to each slice and also gates that slice's carry output. In the wrapper, the carry of each slice drives the second enable of the slice above it, so the chained counter works as one wide binary counter and needs no extra gating logic.

A compile-time parameter selects the clear behaviour. With synchronous clear, the clear is sampled at the rising clock edge. With asynchronous clear, the count drops to zero as soon as the clear goes low. When the asynchronous clear is released, normal operation resumes at the next clock edge.

Top module: `casc_counter_top`

## Requirements
- R1: With `CLEAR_ASYNC`=0, a low `clr_n` at a rising clock edge sets every bit of `q` to 0, whatever `load_n`, `din` and the enables are. While `clr_n` is low, `q` does not change between clock edges.
- R2: With `CLEAR_ASYNC`=1, `q` goes to 0 as soon as `clr_n` falls, with no clock edge needed. After `clr_n` rises, the first update happens at the next rising edge.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`, with `din[0]` going to `q[0]` (the LSB). This happens whatever `count_en` and `chain_en` are.
- R4: When `clr_n`, `load_n`, `count_en` and a slice's chain enable are all high at a rising edge, that slice's 4-bit count goes up by one. A slice at 15 wraps to 0.
- R5: When `clr_n` and `load_n` are high and either enable is low at a rising edge, the count holds its value.
- R6: A slice's carry is high only while its chain enable is high and its count is 15. The carry follows the chain enable without waiting for a clock edge.
- R7: The carry of slice k drives the chain enable of slice k+1, while `count_en`, the clock and the clear are shared by all slices. The full `q` therefore counts as one binary number and wraps from all ones to 0 (from 4095 to 0 with 3 slices).
- R8: `carry_out` is high only while `chain_en` is high and all bits of `q` are 1. During free counting it is high for exactly one cycle per wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous actions happen on its rising edge |
| clr_n | input | 1 | Active-low clear, shared by all slices |
| load_n | input | 1 | Active-low synchronous parallel preset |
| count_en | input | 1 | Global count enable, shared by all slices |
| chain_en | input | 1 | Chain enable of the lowest slice; also gates the carries |
| din | input | 4*NUM_STAGES | Preset data word, bit 0 is the LSB |
| q | output | 4*NUM_STAGES | Counter value, bit 0 is the LSB |
| carry_out | output | 1 | Carry of the highest slice |

## Verification
The functions that can fall in the same cycle are clear and load, and load and count. The bench provokes both overlaps with vectors that drive a low clear and a low load together, and a low load with both enables high. It judges them by checking that the clear or the preset value wins at the next edge. The difference between the two clear modes is provoked by dropping the clear in the middle of a clock period. The asynchronous instance must read zero at once, while the synchronous instance keeps its count until the next edge. The cascade is judged over a full 4096-cycle run by tracking the wide count and counting the cycles in which the carry is high.

// File: rtl/cnt_pkg.sv
// Package: shared width and the operation code used by every counter slice.
// Assumes: slices are always 4 bits wide; wider counters are built by chaining.
package cnt_pkg;
    localparam int NIB_W = 4;

    // Operation a slice performs at the next rising edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_t;
endpackage

// File: rtl/cnt_op_decode.sv
// Module: cnt_op_decode
// Turns the slice controls into one operation code, with clear first, then
// load, then count, then hold.
// Assumes: all inputs are synchronous to the slice clock, except clr_n when
// the register uses the asynchronous clear.
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic clr_n,
    input  logic load_n,
    input  logic en_p,
    input  logic en_t,
    output op_t  op
);
    // Priority encode the slice controls.
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_INC;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_state_reg.sv
// Module: cnt_state_reg
// Holds the slice count. The parameter CLEAR_ASYNC chooses whether clr_n
// acts at once (1) or only at the rising edge (0).
// Assumes: op comes from cnt_op_decode; the load data is stable at the edge.
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int W           = NIB_W,
    parameter bit CLEAR_ASYNC = 1'b0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  op_t          op,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] q_nxt;

    // Next count from the decoded operation.
    always_comb begin
        case (op)
            OP_CLEAR: q_nxt = '0;
            OP_LOAD:  q_nxt = din;
            OP_INC:   q_nxt = q + ONE;
            default:  q_nxt = q;
        endcase
    end

    generate
        if (CLEAR_ASYNC) begin : g_async_clr
            // The count register is cleared at once whenever clr_n falls.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    q <= '0;
                else
                    q <= q_nxt;
            end
        end else begin : g_sync_clr
            // The count register is cleared only at a clock edge (OP_CLEAR).
            always_ff @(posedge clk) begin
                q <= q_nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/cnt_stage.sv
// Module: cnt_stage
// One 4-bit slice: decodes the controls, holds the count and makes the
// carry, which is high while en_t is high and the count is all ones.
// Assumes: en_t comes from the carry of the slice below or from the chain input.
module cnt_stage
    import cnt_pkg::*;
#(
    parameter bit CLEAR_ASYNC = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [NIB_W-1:0] din,
    output logic [NIB_W-1:0] q,
    output logic             carry
);
    localparam logic [NIB_W-1:0] ONE = NIB_W'(1);

    op_t op;

    cnt_op_decode u_dec (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    cnt_state_reg #(
        .W           (NIB_W),
        .CLEAR_ASYNC (CLEAR_ASYNC)
    ) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .din   (din),
        .q     (q)
    );

    // Carry to the next slice: high at terminal count, gated by en_t.
    assign carry = en_t & (&q);

    // R1 and R2: a clear seen at an edge leaves the count at zero at the next
    // edge, in both modes. The clear is the reset here, so no disable applies.
    a_r1_r2_clear: assert property (@(posedge clk)
        !clr_n |=> (q == '0));

    // R3: a load takes the data word, whatever the enables are.
    a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));

    // R4: with both enables high the count goes up by one, 15 wraps to 0.
    a_r4_count: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> (q == $past(q) + ONE));

    // R5: with either enable low the count holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/casc_counter_top.sv
// Module: casc_counter_top
// Chains NUM_STAGES slices: the carry of each slice drives the chain enable
// of the next one, and the clock, clear, load and global enable are shared.
// Assumes: NUM_STAGES >= 1; din is stable around the clock edge.
module casc_counter_top
    import cnt_pkg::*;
#(
    parameter int NUM_STAGES  = 3,
    parameter bit CLEAR_ASYNC = 1'b0
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic                        count_en,
    input  logic                        chain_en,
    input  logic [NIB_W*NUM_STAGES-1:0] din,
    output logic [NIB_W*NUM_STAGES-1:0] q,
    output logic                        carry_out
);
    localparam int TOTAL_W = NIB_W * NUM_STAGES;
    localparam logic [TOTAL_W-1:0] ONE_W = TOTAL_W'(1);

    logic [NUM_STAGES:0] t_chain;

    assign t_chain[0] = chain_en;

    generate
        for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
            cnt_stage #(
                .CLEAR_ASYNC (CLEAR_ASYNC)
            ) u_stage (
                .clk    (clk),
                .clr_n  (clr_n),
                .load_n (load_n),
                .en_p   (count_en),
                .en_t   (t_chain[s]),
                .din    (din[s*NIB_W +: NIB_W]),
                .q      (q[s*NIB_W +: NIB_W]),
                .carry  (t_chain[s+1])
            );
        end
    endgenerate

    assign carry_out = t_chain[NUM_STAGES];

    // R7: the chained slices count as one wide binary number.
    a_r7_cascade_inc: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && count_en && chain_en) |=> (q == $past(q) + ONE_W));

    // R8: the final carry only appears at full count with the chain enabled.
    a_r8_carry_full: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (chain_en && (&q)));
endmodule

// File: tb/casc_counter_top_tb_top.sv
module casc_counter_top_tb_top;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         load_n = 1'b1;
    logic         count_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q_s, q_a;
    logic         co_s, co_a;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;  // 50 MHz

    casc_counter_top #(.NUM_STAGES(3), .CLEAR_ASYNC(1'b0)) dut_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .count_en(count_en),
        .chain_en(chain_en), .din(din), .q(q_s), .carry_out(co_s));

    casc_counter_top #(.NUM_STAGES(3), .CLEAR_ASYNC(1'b1)) dut_async_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .count_en(count_en),
        .chain_en(chain_en), .din(din), .q(q_a), .carry_out(co_a));

    // Vector: [27] clr_n, [26] load_n, [25] count_en, [24] chain_en,
    //         [23:12] din, [11:0] expected q after the edge.
    localparam logic [27:0] VEC_TBL [0:10] = '{
        28'h5000000, 28'h8ABCABC, 28'hF000ABD, 28'hD000ABD,
        28'hE000ABD, 28'h800F00F, 28'hF000010, 28'h3FFE000,
        28'h8FFEFFE, 28'hF000FFF, 28'hF000000
    };

    task automatic chk(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive controls now (5 ns after an edge), then sample 5 ns after the next edge.
    task automatic step(input logic c, input logic l, input logic p,
                        input logic t, input logic [W-1:0] d);
        clr_n = c; load_n = l; count_en = p; chain_en = t; din = d;
        @(posedge clk);
        #5;
    endtask

    function automatic string tag_of(input logic c, input logic l,
                                     input logic p, input logic t);
        if (!c) return "R1";
        if (!l) return "R3";
        if (p && t) return "R4";
        return "R5";
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] model;
        int           pulses;
        bit           seq_ok;

        // Reset state: clear held through the first edge.
        @(posedge clk);
        #5;
        chk("R1 reset", q_s, 12'h000);
        chk("R2 reset", q_a, 12'h000);

        // Table walk.
        for (int i = 0; i < 11; i++) begin
            logic [27:0] v;
            v = VEC_TBL[i];
            step(v[27], v[26], v[25], v[24], v[23:12]);
            chk(tag_of(v[27], v[26], v[25], v[24]), q_s, v[11:0]);
        end

        // Every control combination against a model built from R1, R3, R4, R5.
        for (int m = 0; m < 16; m++) begin
            logic c, l, p, t;
            {c, l, p, t} = 4'(m);
            step(1'b1, 1'b0, 1'b0, 1'b0, 12'h0EF);
            if (!c)           model = 12'h000;
            else if (!l)      model = 12'h5A3;
            else if (p && t)  model = 12'h0F0;
            else              model = 12'h0EF;
            step(c, l, p, t, 12'h5A3);
            chk(tag_of(c, l, p, t), q_s, model);
        end

        // R6/R8: carry follows chain_en without a clock edge.
        step(1'b1, 1'b0, 1'b0, 1'b1, 12'hFFF);
        #1;
        chk("R8 carry at full count", {11'd0, co_s}, 12'd1);
        chain_en = 1'b0;
        #1;
        chk("R6 carry gated by enable", {11'd0, co_s}, 12'd0);
        chain_en = 1'b1;
        #1;
        chk("R6 carry returns", {11'd0, co_s}, 12'd1);
        step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000);
        chk("R5 hold at full count", q_s, 12'hFFF);

        // R1 versus R2: clear dropped in mid period.
        step(1'b1, 1'b0, 1'b0, 1'b0, 12'h123);
        chk("R3 load sync", q_s, 12'h123);
        chk("R3 load async", q_a, 12'h123);
        clr_n = 1'b0;
        #2;
        chk("R2 immediate clear", q_a, 12'h000);
        chk("R1 waits for edge", q_s, 12'h123);
        @(posedge clk);
        #5;
        chk("R1 clear at edge", q_s, 12'h000);
        clr_n = 1'b1; load_n = 1'b1; count_en = 1'b1; chain_en = 1'b1;
        #2;
        chk("R2 release holds zero", q_a, 12'h000);
        @(posedge clk);
        #5;
        chk("R2 resumes at edge", q_a, 12'h001);
        chk("R4 count after clear", q_s, 12'h001);

        // R7/R8: full run through 4095 and the wrap.
        step(1'b0, 1'b1, 1'b1, 1'b1, 12'h000);
        pulses = 0;
        seq_ok = 1'b1;
        for (int k = 1; k <= 4096; k++) begin
            step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
            if (q_s !== 12'(k)) seq_ok = 1'b0;
            if (co_s) pulses++;
        end
        chk("R7 cascade sequence", {11'd0, seq_ok}, 12'd1);
        chk("R7 wrap to zero", q_s, 12'h000);
        chk("R8 one carry per wrap", 12'(pulses), 12'd1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule